// File: doc/BRIEF.md
# Change-Within-Window Monitor

A synthesizable checking block that watches a multi-bit value and expects that value to move soon after an arming event. When the start input is sampled high on a rising clock edge while the block is idle, the present watched value is stored as a reference and a window of `NUM_CKS` clock edges opens. On each of those edges the watched value is compared with the reference. The first difference closes the window early with no complaint. If all `NUM_CKS` samples still match the reference, the block raises a one-cycle error pulse.

The block is meant to sit beside a datapath or a control register inside a larger design. It can also serve as a run-time watchdog for a value that must respond to a command. It holds only the reference value, a small cycle counter and a one-bit armed state. Arming requests that arrive during an open window are dropped. Overlapping checks therefore never restart or stretch a window.

Top module: `change_window_monitor`

## Requirements
- R1: While `rst_n` is low, `err_o` is 0 and the block is idle. The first start after reset release is accepted.
- R2: A start sampled while idle stores the watched value present on that same edge as the reference. A value seen on an earlier edge is not stored.
- R3: After arming, the watched value is compared with the reference on each of the next `NUM_CKS` rising edges, and on no others.
- R4: If all `NUM_CKS` samples equal the reference, `err_o` is 1 for the clock cycle that follows the `NUM_CKS`-th edge after the arming edge. The block is then idle.
- R5: If any sample in the window differs from the reference, including the last one, no error is raised and the window closes on that edge.
- R6: A start sampled while a window is open is ignored. The window keeps its original reference and its original end edge.
- R7: `err_o` is high for exactly one cycle per expired window. It is never high in two consecutive cycles.
- R8: The watched value is `WIDTH` bits wide, and a difference in any single bit counts as a change, the most significant bit included. `WIDTH` and `NUM_CKS` must both be at least 1, and this is checked at elaboration.
- R9: A value that leaves the reference and later comes back to it still counts as a change. The window closed on the first difference, so no error is raised.
- R10: A start on the edge that ends a window is ignored. A start one cycle later, in the cycle where `err_o` is high, arms a new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arming event; effective only while idle |
| watch_i | input | WIDTH | Value expected to change within the window |
| err_o | output | 1 | Registered one-cycle pulse when a window expires unchanged |

## Verification
The bench targets the last edge of the window. A design off by one there would either flag a value that changed on the final sample or flag one cycle late. Arming requests are sent while a window is open and on its closing edge. A design that re-arms on those requests would move the expiry edge or store a new reference. A value that leaves the reference and returns is used to catch a design that compares only at expiry. A change confined to the top bit is used to catch a comparator that is narrower than `WIDTH`.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
   typedef enum logic {
      CWM_IDLE  = 1'b0,
      CWM_ARMED = 1'b1
   } cwm_state_e;
endpackage

// File: rtl/cwm_ref_hold.sv
module cwm_ref_hold #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] value_i,
   output logic [WIDTH-1:0] ref_o,
   output logic             differ_o
);
   logic [WIDTH-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold_q <= '0;
      else if (load_i) hold_q <= value_i;
   end

   assign ref_o    = hold_q;
   assign differ_o = |(hold_q ^ value_i);
endmodule

// File: rtl/cwm_window_timer.sv
module cwm_window_timer #(
   parameter int NUM_CKS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic adv_i,
   output logic last_o
);
   generate
      if (NUM_CKS == 1) begin : g_single
         logic unused_timer;
         assign unused_timer = clk ^ rst_n ^ clear_i ^ adv_i;
         assign last_o = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(NUM_CKS);
         localparam logic [CW-1:0] LAST = CW'(NUM_CKS - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (clear_i) cnt_q <= '0;
            else if (adv_i)   cnt_q <= cnt_q + 1'b1;
         end

         assign last_o = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/change_window_monitor.sv
module change_window_monitor #(
   parameter int WIDTH   = 8,
   parameter int NUM_CKS = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [WIDTH-1:0] watch_i,
   output logic             err_o
);
   import cwm_pkg::*;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("change_window_monitor: WIDTH must be at least 1");
      end
      if (NUM_CKS < 1) begin : g_bad_window
         $error("change_window_monitor: NUM_CKS must be at least 1");
      end
   endgenerate

   cwm_state_e       state_q;
   logic             err_q;
   logic             active_q;
   logic             load;
   logic             differ;
   logic             last;
   logic             adv;
   logic [WIDTH-1:0] ref_q;

   assign active_q = (state_q == CWM_ARMED);
   assign load     = !active_q && start_i;
   assign adv      = active_q && !differ && !last;

   cwm_ref_hold #(.WIDTH(WIDTH)) u_ref (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .value_i  (watch_i),
      .ref_o    (ref_q),
      .differ_o (differ)
   );

   cwm_window_timer #(.NUM_CKS(NUM_CKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (load),
      .adv_i   (adv),
      .last_o  (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CWM_IDLE;
         err_q   <= 1'b0;
      end else begin
         err_q <= 1'b0;
         case (state_q)
            CWM_IDLE: begin
               if (start_i) state_q <= CWM_ARMED;
            end
            CWM_ARMED: begin
               if (differ) begin
                  state_q <= CWM_IDLE;
               end else if (last) begin
                  state_q <= CWM_IDLE;
                  err_q   <= 1'b1;
               end
            end
            default: state_q <= CWM_IDLE;
         endcase
      end
   end

   assign err_o = err_q;
endmodule

// File: rtl/change_window_monitor_chk.sv
module change_window_monitor_chk #(
   parameter int WIDTH   = 8,
   parameter int NUM_CKS = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [WIDTH-1:0] watch_i,
   input logic             err_o,
   input logic             active_q,
   input logic [WIDTH-1:0] ref_q
);
   localparam int RW = $clog2(NUM_CKS + 2);
   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_q <= '0;
      else if (active_q) run_q <= run_q + 1'b1;
      else               run_q <= '0;
   end

   p_arm_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !active_q) |=> (active_q && ref_q == $past(watch_i)));

   p_change_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && watch_i != ref_q) |=> (!active_q && !err_o));

   p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && start_i && watch_i == ref_q) |=> (ref_q == $past(ref_q)));

   p_err_after_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> ($past(active_q) && $past(watch_i == ref_q) && run_q == RW'(NUM_CKS)));

   p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);

   p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (run_q < RW'(NUM_CKS)));
endmodule

bind change_window_monitor change_window_monitor_chk #(
   .WIDTH   (WIDTH),
   .NUM_CKS (NUM_CKS)
) u_chk (.*);

// File: tb/change_window_monitor_test.sv
module change_window_monitor_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int N = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [W-1:0] watch_i = '0;
   logic         err_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic         m_active = 1'b0;
   logic [W-1:0] m_ref = '0;
   int           m_cnt = 0;
   logic         m_err = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   change_window_monitor #(.WIDTH(W), .NUM_CKS(N)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .watch_i (watch_i),
      .err_o   (err_o)
   );

   // expected error flag for the cycle after an edge, from the requirements
   function automatic logic exp_err(input logic act, input logic [W-1:0] rf,
                                    input int cnt, input logic [W-1:0] w);
      return act && (w == rf) && (cnt == N - 1);
   endfunction

   task automatic model_edge(input logic s, input logic [W-1:0] w);
      m_err = exp_err(m_active, m_ref, m_cnt, w);
      if (!m_active) begin
         if (s) begin
            m_active = 1'b1;
            m_ref    = w;
            m_cnt    = 0;
         end
      end else if (w != m_ref || m_err) begin
         m_active = 1'b0;
      end else begin
         m_cnt = m_cnt + 1;
      end
   endtask

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: err_o=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic s, input logic [W-1:0] w, input string tag);
      @(negedge clk);
      start_i = s;
      watch_i = w;
      @(posedge clk);
      model_edge(s, w);
      #1;
      check(err_o, m_err, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset holds err_o low
      repeat (3) @(posedge clk);
      #1;
      check(err_o, 1'b0, "R1 reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R1/R4: first start after reset, value held -> pulse after N edges
      step(1'b1, 8'h5A, "R1 arm");
      for (int i = 0; i < N; i++) step(1'b0, 8'h5A, "R4 hold");
      step(1'b0, 8'h5A, "R7 pulse drop");

      // R2: value before arming differs from value at arming edge
      step(1'b0, 8'h11, "R2 pre");
      step(1'b1, 8'h22, "R2 arm");
      for (int i = 0; i < N; i++) step(1'b0, 8'h22, "R2 captured value");
      step(1'b0, 8'h22, "R2 idle");

      // R5: change on the last sample -> no error
      step(1'b1, 8'h30, "R5 arm");
      for (int i = 0; i < N - 1; i++) step(1'b0, 8'h30, "R5 hold");
      step(1'b0, 8'h31, "R5 last-sample change");
      step(1'b0, 8'h31, "R5 quiet");
      step(1'b0, 8'h31, "R5 quiet");

      // R5: change on the first sample, then a fresh start is accepted
      step(1'b1, 8'h40, "R5 arm2");
      step(1'b0, 8'h41, "R5 first-sample change");
      step(1'b1, 8'h41, "R5 rearm");
      for (int i = 0; i < N; i++) step(1'b0, 8'h41, "R5 rearm hold");
      step(1'b0, 8'h41, "R5 rearm idle");

      // R9: leave and return to reference
      step(1'b1, 8'h66, "R9 arm");
      step(1'b0, 8'h66, "R9 hold");
      step(1'b0, 8'h67, "R9 leave");
      for (int i = 0; i < N; i++) step(1'b0, 8'h66, "R9 back no error");

      // R6: start pulses during the window neither extend nor re-capture
      step(1'b1, 8'h70, "R6 arm");
      for (int i = 0; i < N; i++) step(1'b1, 8'h70, "R6 busy start");
      step(1'b0, 8'h70, "R6 window not extended");

      // R10: start on expiry edge ignored; start while err_o high accepted
      step(1'b0, 8'h00, "R10 idle");
      step(1'b1, 8'h80, "R10 arm");
      for (int i = 0; i < N - 1; i++) step(1'b0, 8'h80, "R10 hold");
      step(1'b1, 8'h80, "R10 start on expiry edge");
      step(1'b1, 8'h80, "R10 start during pulse");
      for (int i = 0; i < N; i++) step(1'b0, 8'h80, "R10 second window");
      step(1'b0, 8'h80, "R10 idle after");

      // R8: a change only in the top bit counts
      step(1'b1, 8'h0F, "R8 arm");
      step(1'b0, 8'h0F, "R8 hold");
      step(1'b0, 8'h8F, "R8 msb change");
      for (int i = 0; i < N; i++) step(1'b0, 8'h8F, "R8 no error");

      // R3/R4/R5/R6: constrained random
      begin
         logic [W-1:0] w;
         void'($urandom(32'h1234_5678));
         w = 8'h03;
         for (int i = 0; i < 3000; i++) begin
            if (($urandom % 100) < 12) w = W'($urandom % 3);
            step(($urandom % 100) < 30, w, "R3 random");
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule